// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a four-wire control bus that lets a host processor program a bank of byte-wide configuration registers. The host pulls chip select low, then toggles the control clock while it shifts a 16-bit frame into the data input. The first byte carries a direction flag in its top bit and a 7-bit register address. For a write, the second byte is the new register value. For a read, the block drives the addressed register's contents on its data output during the second byte.

The control clock has no fixed relation to the core clock and may run at up to 4 MHz. Every completed write is held in a stable register in the control-clock domain. A toggle carries the event across, through a two-stage synchronizer, and produces a one-cycle strobe in the core domain. The strobe has no ready: the serial master cannot be stalled, so the register bank must take each strobe in the cycle it appears. Frames are at least sixteen control-clock periods apart, which leaves the core many cycles per write.

The bank holds `NREG` registers. One bit, at a parameterised address, is a soft-reset command that the core sees as a pulse.

Top module: `ctl_serial_port`

## Requirements
- R1: After core reset, with chip select high, wr_valid, soft_rst and co_oe are all low.
- R2: A frame is sampled on rising control-clock edges, MSB first. Bit 15 = 0 selects a write, bits 14..8 give the address and bits 7..0 the data. At the 16th rising edge the address and data appear on wr_addr/wr_data with wr_valid high.
- R3: Each completed write produces exactly one wr_valid cycle in the core domain.
- R4: If chip select rises before the 16th rising edge, no write is issued.
- R5: A write to an address of NREG (41) or above is dropped, so wr_valid never carries such an address.
- R6: A frame with bit 15 = 1 is a read. co_oe stays low during the first eight clock pulses. From the falling edge of pulse 8, the register byte is driven MSB first, and each next bit follows on a later falling edge. co_oe drops on the falling edge of pulse 16.
- R7: A read of an address of NREG or above returns 00h.
- R8: During a read, rd_addr presents the frame's address so that the bank can return rd_data.
- R9: A write of address RST_ADDR (0) with bit RST_BIT (7) set raises soft_rst in the same cycle as wr_valid. If that bit is clear, soft_rst stays low.
- R10: Chip select high forces co_oe low.
- R11: Clock pulses beyond the sixteenth in one frame have no effect: no second write and no output drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| cclk | input | 1 | Serial control clock, asynchronous to clk |
| ci | input | 1 | Serial data in |
| co | output | 1 | Serial data out |
| co_oe | output | 1 | Output enable for co (tristate control) |
| rd_addr | output | 7 | Address of the register being read |
| rd_data | input | 8 | Register contents at rd_addr |
| wr_valid | output | 1 | One-cycle write strobe, core domain |
| wr_addr | output | 7 | Write address, valid with wr_valid |
| wr_data | output | 8 | Write data, valid with wr_valid |
| soft_rst | output | 1 | Soft-reset pulse, core domain |

## Verification
The bench aims at the edges of a frame. It cuts frames off after 12 and 15 pulses, where a design that committed early would write a stale or half-shifted byte. It runs a 20-pulse frame, which a counter that wraps would turn into a second write. It uses addresses 40, 41 and 127 to catch an off-by-one limit, which would pass writes to or read back garbage from nonexistent registers. Read frames check co_oe pulse by pulse, so an output enabled one pulse early or late, or shifted on the wrong edge, shows up as a wrong bit. The soft-reset writes, with the command bit set and clear, show any decode that ignores the data bit.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/csp_shifter.sv
module csp_shifter
  import ctl_pkg::*;
#(
  parameter int NREG = 41
) (
  input  logic              cclk,
  input  logic              cs_n,
  input  logic              rst_n,
  input  logic              ci,
  output logic [4:0]        cnt,
  output cmd_t              cmd,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              tog
);
  localparam logic [4:0]        FULL   = 5'(2*DATA_W);
  localparam logic [4:0]        LAST   = 5'(2*DATA_W-1);
  localparam logic [4:0]        CMDL   = 5'(DATA_W-1);
  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] nxt;

  assign nxt = {sr[DATA_W-2:0], ci};

  // Frame state, cleared whenever chip select is high.
  always_ff @(posedge cclk or posedge cs_n) begin
    if (cs_n) begin
      cnt <= '0;
      sr  <= '0;
      cmd <= '0;
    end else if (cnt != FULL) begin
      cnt <= cnt + 5'd1;
      sr  <= nxt;
      if (cnt == CMDL) cmd <= cmd_t'(nxt);
    end
  end

  // Committed write; survives chip select and is read by the core domain.
  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_data <= '0;
      tog       <= 1'b0;
    end else if (cnt == LAST && !cmd.rd && cmd.addr < NREG_A) begin
      hold_addr <= cmd.addr;
      hold_data <= nxt;
      tog       <= ~tog;
    end
  end

  assert_commit_at_end_R4: assert property (@(posedge cclk) disable iff (!rst_n)
    !$stable(tog) |-> $past(cnt) == LAST);
  assert_hold_range_R5: assert property (@(posedge cclk) disable iff (!rst_n)
    hold_addr < NREG_A);
endmodule

// File: rtl/csp_readout.sv
module csp_readout
  import ctl_pkg::*;
#(
  parameter int NREG = 41
) (
  input  logic              cclk,
  input  logic              cs_n,
  input  logic [4:0]        cnt,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] rd_data,
  output logic              co,
  output logic              co_oe
);
  localparam logic [4:0]        HALF   = 5'(DATA_W);
  localparam logic [4:0]        FULL   = 5'(2*DATA_W);
  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

  logic [DATA_W-1:0] osr;
  logic [DATA_W-1:0] rd_byte;

  assign rd_byte = (cmd.addr < NREG_A) ? rd_data : '0;
  assign co      = osr[DATA_W-1];

  always_ff @(negedge cclk or posedge cs_n) begin
    if (cs_n) begin
      osr   <= '0;
      co_oe <= 1'b0;
    end else if (cnt == HALF && cmd.rd) begin
      osr   <= rd_byte;
      co_oe <= 1'b1;
    end else if (cnt == FULL) begin
      co_oe <= 1'b0;
    end else if (co_oe) begin
      osr <= {osr[DATA_W-2:0], 1'b0};
    end
  end

  assert_quiet_first_byte_R6: assert property (@(posedge cclk) disable iff (cs_n)
    (cnt < HALF) |-> !co_oe);
  assert_drive_only_reads_R6: assert property (@(posedge cclk) disable iff (cs_n)
    co_oe |-> cmd.rd);
endmodule

// File: rtl/csp_cdc.sv
module csp_cdc
  import ctl_pkg::*;
#(
  parameter int NREG     = 41,
  parameter int RST_ADDR = 0,
  parameter int RST_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tog,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              soft_rst
);
  localparam logic [ADDR_W-1:0] RST_A  = ADDR_W'(RST_ADDR);
  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

  logic [2:0] sync;
  logic       edge_seen;

  assign edge_seen = sync[1] ^ sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      soft_rst <= 1'b0;
    end else begin
      sync     <= {sync[1:0], tog};
      wr_valid <= edge_seen;
      soft_rst <= edge_seen && hold_addr == RST_A && hold_data[RST_BIT];
      if (edge_seen) begin
        wr_addr <= hold_addr;
        wr_data <= hold_data;
      end
    end
  end

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  assert_srst_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> wr_valid && wr_addr == RST_A);
  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr < NREG_A);
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_pkg::*;
#(
  parameter int NREG     = 41,
  parameter int RST_ADDR = 0,
  parameter int RST_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cclk,
  input  logic              ci,
  output logic              co,
  output logic              co_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              soft_rst
);
  logic [4:0]        cnt;
  cmd_t              cmd;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              tog;

  assign rd_addr = cmd.addr;

  csp_shifter #(.NREG(NREG)) u_shift (
    .cclk(cclk), .cs_n(cs_n), .rst_n(rst_n), .ci(ci), .cnt(cnt), .cmd(cmd),
    .hold_addr(hold_addr), .hold_data(hold_data), .tog(tog)
  );

  csp_readout #(.NREG(NREG)) u_read (
    .cclk(cclk), .cs_n(cs_n), .cnt(cnt), .cmd(cmd), .rd_data(rd_data),
    .co(co), .co_oe(co_oe)
  );

  csp_cdc #(.NREG(NREG), .RST_ADDR(RST_ADDR), .RST_BIT(RST_BIT)) u_cdc (
    .clk(clk), .rst_n(rst_n), .tog(tog), .hold_addr(hold_addr),
    .hold_data(hold_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .soft_rst(soft_rst)
  );
endmodule

// File: tb/tb_ctl_serial_port.sv
module tb_ctl_serial_port;
  logic       clk = 0, rst_n = 0, cs_n = 1, cclk = 0, ci = 0;
  logic       co, co_oe, wr_valid, soft_rst;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  int         n_run = 0, n_fail = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  // Register bank model: contents are a fixed function of the address.
  function automatic logic [7:0] bank(input logic [6:0] a);
    return {a[3:0], ~a[3:0]} ^ 8'h30;
  endfunction
  assign rd_data = bank(rd_addr);

  ctl_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cclk(cclk), .ci(ci), .co(co),
    .co_oe(co_oe), .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .soft_rst(soft_rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each strobe must match the oldest expected write.
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R3/R4/R5/R11 unexpected write", {soft_rst, wr_addr, wr_data}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({soft_rst, wr_addr, wr_data} == e, "R2/R9 write item",
              {soft_rst, wr_addr, wr_data}, e);
      end
    end else if (rst_n && soft_rst) begin
      check(0, "R9 soft_rst without write", 1, 0);
    end
  end

  // Drives one frame of n pulses; returns the byte seen on co in pulses 9..16.
  task automatic xfer(input logic [15:0] w, input int n, output logic [7:0] got,
                      output int oe_err);
    got = 0; oe_err = 0;
    cs_n = 0; #37;
    for (int i = 0; i < n; i++) begin
      ci = (i < 16) ? w[15-i] : 1'b0;
      #100;
      if (i >= 8 && i < 16) begin
        got = {got[6:0], co};
        if (co_oe !== w[15]) oe_err++;
        if (w[15] && rd_addr !== w[14:8]) oe_err++;
      end else if (co_oe !== 1'b0) oe_err++;
      cclk = 1; #100; cclk = 0;
    end
    #50;
    if (n >= 16 && co_oe !== 1'b0) oe_err++;
    cs_n = 1; #1;
    check(co_oe === 1'b0, "R10 co_oe with cs_n high", co_oe, 0);
    #300;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input int n, input bit expect_it);
    logic [7:0] g; int e;
    if (expect_it) exp_q.push_back({(a == 7'd0 && d[7]), a, d});
    xfer({1'b0, a, d}, n, g, e);
    check(e == 0, "R6 co_oe idle during write", e, 0);
  endtask

  task automatic rd(input logic [6:0] a);
    logic [7:0] g, x; int e;
    x = (a < 7'd41) ? bank(a) : 8'h00;
    xfer({1'b1, a, 8'h00}, 16, g, e);
    check(e == 0, "R6/R8 co_oe window and rd_addr", e, 0);
    check(g == x, (a < 7'd41) ? "R6/R8 read byte" : "R7 read out of range", g, x);
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #23; rst_n = 1; #50;
    check(wr_valid === 0 && soft_rst === 0, "R1 reset outputs", {wr_valid, soft_rst}, 0);
    check(co_oe === 0, "R1 co_oe after reset", co_oe, 0);
    wr(7'd5,  8'hA5, 16, 1);   // R2
    wr(7'd40, 8'h3C, 16, 1);   // R2 last register
    wr(7'd41, 8'h11, 16, 0);   // R5
    wr(7'd127, 8'h22, 16, 0);  // R5
    wr(7'd3,  8'h44, 12, 0);   // R4
    wr(7'd3,  8'h55, 15, 0);   // R4
    wr(7'd7,  8'h81, 20, 1);   // R11, R3
    wr(7'd0,  8'h80, 16, 1);   // R9 set
    wr(7'd0,  8'h7F, 16, 1);   // R9 clear
    rd(7'd12);                 // R6 R8
    rd(7'd40);
    rd(7'd0);
    rd(7'd41);                 // R7
    rd(7'd100);                // R7
    #1000;
    check(exp_q.size() == 0, "R3 missing writes", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule